// File: doc/BRIEF.md
# Time-Slot Mapped HDLC Receiver

This block recovers HDLC frames from a serial TDM stream of 32 slots of 8 bits each. A frame-sync pulse marks the first bit of every TDM frame. A slot-select mask picks which slots feed the HDLC path. A bit-suppress mask removes chosen bit positions inside those slots. The surviving bits form one continuous serial HDLC stream. Byte boundaries in that stream follow the HDLC flags, not the slot edges.

On the HDLC stream the receiver hunts for flags and strips zeros inserted by the transmitter. It assembles bytes from the first bit after a flag, checks the frame check sequence and detects abort runs. Payload bytes are written into a 256-entry receive FIFO. The frame check bytes are never stored. Each stored word carries the byte, an end-of-packet tag and a 2-bit status. The status is meaningful on the end-of-packet word.

The host pops words from a first-word-fall-through read port. It also sees the fill level, empty and full flags, and a sticky overrun flag that it clears with a pulse.

Top module: `hdlc_tdm_rx`

## Requirements
- R1: Only bits from slots whose `slot_mask` bit is 1 enter the HDLC stream. Slot n is made of TDM bit indices 8n to 8n+7, where index 0 is the bit received with `tdm_fsync` high and each `tdm_bit_en` cycle advances the index by one.
- R2: Bit k of `bit_sup` (k = 0 is the first bit received in a slot) drops the k-th bit of every selected slot from the HDLC stream.
- R3: A 0 that follows a 0 and then five 1s is removed from the data, and it does not count as a data bit.
- R4: The pattern 01111110 is a flag. It opens a frame, and it also closes a frame that is open. Data bits are packed least significant bit first, starting with the first bit after the flag.
- R5: The last two bytes of a frame are the check sequence and are not stored. The check uses CRC-16 with polynomial x^16+x^12+x^5+1, bit-reflected, initial value FFFF, complemented, and sent low byte first. The last stored byte has `rd_eop`=1 and `rd_stat`=0 when the check matches and the frame is a whole number of bytes. Otherwise it has `rd_stat`=1.
- R6: Seven consecutive 1s abort the open frame. Its last stored byte carries `rd_stat`=2. Nothing more is stored until the next flag.
- R7: A frame with fewer than 4 bytes between its flags (check sequence included) leaves nothing in the FIFO.
- R8: The FIFO holds 256 words and shows its head word while `rd_empty`=0. `rd_en` pops one word. `rd_level` is the number of stored words, and `rd_full` is set at 256.
- R9: A write attempted while the FIFO is full is dropped and sets `ovr_flag`. The flag stays set until `ovr_clr` is pulsed. The frame's end-of-packet word then carries `rd_stat`=3, which takes priority over statuses 2 and 1.
- R10: After reset the FIFO is empty, its level is 0, and `rd_full` and `ovr_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tdm_bit_en | input | 1 | A TDM bit is present this cycle |
| tdm_fsync | input | 1 | Current bit is TDM bit index 0 |
| tdm_data | input | 1 | Serial TDM data |
| slot_mask | input | 32 | Slot-select mask |
| bit_sup | input | 8 | Bit-suppress mask, per bit position in a slot |
| rd_en | input | 1 | Pop the head FIFO word |
| rd_data | output | 8 | Head word data byte |
| rd_eop | output | 1 | Head word ends a frame |
| rd_stat | output | 2 | Frame status: 0 good, 1 CRC/length error, 2 abort, 3 overrun |
| rd_level | output | 9 | Stored word count |
| rd_empty | output | 1 | FIFO empty |
| rd_full | output | 1 | FIFO full |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |

## Verification
Several properties are checked on every cycle:
- A stuffed zero never advances byte assembly.
- After an abort the receiver is out of frame.
- End-of-packet words appear only on a closing flag or an abort, and only after three bytes have been held back.
- The FIFO is never written while full, and its level moves by one.
- The overrun flag stays set until it is cleared.

Other behaviour can only be shown by the bench's streams, because the expected result depends on the whole frame:
- the slot and bit masks pick exactly the right bits;
- the check sequence is validated and removed;
- short frames vanish, and misaligned or aborted frames get the right status;
- an overrun mid-frame is reported on the right word.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    ST_GOOD  = 2'd0,
    ST_BAD   = 2'd1,
    ST_ABORT = 2'd2,
    ST_OVR   = 2'd3
  } rx_stat_e;

  typedef struct packed {
    logic [7:0] data;
    logic       eop;
    rx_stat_e   stat;
  } rx_word_t;

  localparam logic [15:0] FCS_INIT = 16'hFFFF;
  localparam logic [15:0] FCS_POLY = 16'h8408;
  localparam logic [15:0] FCS_GOOD = 16'hF0B8;

  // Bitwise reflected CRC-16 update over one byte, LSB first.
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ FCS_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Length of the current run of ones, saturating at 7.
  function automatic logic [2:0] run_next(input logic [2:0] run, input logic b);
    if (!b) return 3'd0;
    return (run == 3'd7) ? 3'd7 : run + 3'd1;
  endfunction
endpackage

// File: rtl/tdm_slot_gate.sv
module tdm_slot_gate #(
  parameter int SLOTS         = 32,
  parameter int BITS_PER_SLOT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic                     fsync,
  input  logic                     din,
  input  logic [SLOTS-1:0]         slot_mask,
  input  logic [BITS_PER_SLOT-1:0] bit_sup,
  output logic                     hbit_vld,
  output logic                     hbit
);
  localparam int BW = $clog2(BITS_PER_SLOT);
  localparam int IW = $clog2(SLOTS * BITS_PER_SLOT);

  logic [IW-1:0] pos_q, pos_now;
  logic [IW-BW-1:0] slot_idx;
  logic [BW-1:0] bit_idx;

  function automatic logic picked(input logic [SLOTS-1:0] sm, input logic [BITS_PER_SLOT-1:0] bs,
                                  input logic [IW-BW-1:0] s, input logic [BW-1:0] b);
    return sm[s] && !bs[b];
  endfunction

  assign pos_now  = fsync ? '0 : pos_q;
  assign slot_idx = pos_now[IW-1:BW];
  assign bit_idx  = pos_now[BW-1:0];
  assign hbit_vld = bit_en && picked(slot_mask, bit_sup, slot_idx, bit_idx);
  assign hbit     = din;

  always_ff @(posedge clk) begin
    if (!rst_n)      pos_q <= '0;
    else if (bit_en) pos_q <= pos_now + IW'(1);
  end

  // R1: a frame-sync bit restarts the index so the next bit is index 1
  p_fsync_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync |=> pos_q == IW'(1));
endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_vld,
  input  logic     bit_in,
  input  logic     fifo_full,
  output logic     wr_en,
  output rx_word_t wr_word,
  output logic     ovr_ev
);
  logic [2:0]  ones_q;
  logic        open_q;
  logic [7:0]  sh_q, h0_q, h1_q, h2_q;
  logic [2:0]  bcnt_q;
  logic [3:0]  nbytes_q;
  logic [15:0] crc_q;
  logic        fovr_q;

  // Named events on the HDLC stream.
  logic ev_stuff, ev_flag, ev_abort, ev_data, byte_done;
  logic push_data, close_ok, close_abort, wr_req;
  logic [7:0] new_byte;
  rx_stat_e   close_stat;

  assign ev_stuff  = bit_vld && !bit_in && ones_q == 3'd5;
  assign ev_flag   = bit_vld && !bit_in && ones_q == 3'd6;
  assign ev_abort  = bit_vld &&  bit_in && ones_q == 3'd6;
  assign ev_data   = bit_vld && open_q && ones_q < 3'd5;
  assign new_byte  = {bit_in, sh_q[7:1]};
  assign byte_done = ev_data && bcnt_q == 3'd7;

  assign push_data   = byte_done && nbytes_q >= 4'd3;
  assign close_ok    = ev_flag  && open_q && nbytes_q >= 4'd4;
  assign close_abort = ev_abort && open_q && nbytes_q >= 4'd4;
  assign wr_req      = push_data || close_ok || close_abort;
  assign wr_en       = wr_req && !fifo_full;
  assign ovr_ev      = wr_req && fifo_full;

  always_comb begin
    if (fovr_q)                                   close_stat = ST_OVR;
    else if (close_abort)                         close_stat = ST_ABORT;
    else if (bcnt_q != 3'd6 || crc_q != FCS_GOOD) close_stat = ST_BAD;
    else                                          close_stat = ST_GOOD;
    wr_word.data = h2_q;
    wr_word.eop  = close_ok || close_abort;
    wr_word.stat = (close_ok || close_abort) ? close_stat : ST_GOOD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0; open_q <= 1'b0; sh_q <= '0; bcnt_q <= '0; nbytes_q <= '0;
      h0_q <= '0; h1_q <= '0; h2_q <= '0; crc_q <= FCS_INIT; fovr_q <= 1'b0;
    end else begin
      if (bit_vld) ones_q <= run_next(ones_q, bit_in);
      if (ev_flag) begin
        open_q <= 1'b1; bcnt_q <= '0; nbytes_q <= '0; crc_q <= FCS_INIT; fovr_q <= 1'b0;
      end else begin
        if (ev_abort) open_q <= 1'b0;
        if (ovr_ev)   fovr_q <= 1'b1;
        if (ev_data) begin
          sh_q   <= new_byte;
          bcnt_q <= bcnt_q + 3'd1;
          if (byte_done) begin
            crc_q <= fcs_step(crc_q, new_byte);
            h0_q <= new_byte; h1_q <= h0_q; h2_q <= h1_q;
            if (nbytes_q != 4'hF) nbytes_q <= nbytes_q + 4'd1;
          end
        end
      end
    end
  end

  // R3: a stuffed zero leaves byte assembly where it was
  p_stuff_keeps_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stuff |=> bcnt_q == $past(bcnt_q));
  // R6: an abort leaves the receiver out of frame
  p_abort_hunt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !open_q);
  // R4: end-of-packet words only come from a closing flag or an abort
  p_eop_on_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_word.eop |-> ev_flag || ev_abort);
  // R7: no word is stored before three bytes are held back
  p_no_short_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> nbytes_q >= 4'd3);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [$clog2(DEPTH):0] level,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          pop;

  assign empty   = cnt_q == '0;
  assign full    = cnt_q == FULL_LVL;
  assign level   = cnt_q;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + AW'(1);
      if (pop)   rp_q <= rp_q + AW'(1);
      if (wr_en && !pop)      cnt_q <= cnt_q + (AW+1)'(1);
      else if (pop && !wr_en) cnt_q <= cnt_q - (AW+1)'(1);
    end
  end

  // R9: the writer never pushes into a full FIFO
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);
  // R8: a lone push raises the level by exactly one
  p_level_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en |=> level == $past(level) + (AW+1)'(1));
  // R8: a lone pop of a non-empty FIFO lowers the level by one
  p_level_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !empty && !wr_en |=> level == $past(level) - (AW+1)'(1));
endmodule

// File: rtl/hdlc_tdm_rx.sv
module hdlc_tdm_rx
  import hdlc_rx_pkg::*;
#(
  parameter int SLOTS         = 32,
  parameter int BITS_PER_SLOT = 8,
  parameter int FIFO_DEPTH    = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tdm_bit_en,
  input  logic                          tdm_fsync,
  input  logic                          tdm_data,
  input  logic [SLOTS-1:0]              slot_mask,
  input  logic [BITS_PER_SLOT-1:0]      bit_sup,
  input  logic                          rd_en,
  output logic [7:0]                    rd_data,
  output logic                          rd_eop,
  output logic [1:0]                    rd_stat,
  output logic [$clog2(FIFO_DEPTH):0]   rd_level,
  output logic                          rd_empty,
  output logic                          rd_full,
  output logic                          ovr_flag,
  input  logic                          ovr_clr
);
  localparam int WW = $bits(rx_word_t);

  logic     hbit_vld, hbit, wr_en, ovr_ev, ovr_q;
  rx_word_t wr_word, head;
  logic [WW-1:0] head_raw;

  tdm_slot_gate #(.SLOTS(SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT)) u_gate (
    .clk(clk), .rst_n(rst_n), .bit_en(tdm_bit_en), .fsync(tdm_fsync), .din(tdm_data),
    .slot_mask(slot_mask), .bit_sup(bit_sup), .hbit_vld(hbit_vld), .hbit(hbit));

  hdlc_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .bit_vld(hbit_vld), .bit_in(hbit), .fifo_full(rd_full),
    .wr_en(wr_en), .wr_word(wr_word), .ovr_ev(ovr_ev));

  rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_word), .rd_en(rd_en),
    .rd_data(head_raw), .level(rd_level), .empty(rd_empty), .full(rd_full));

  assign head     = rx_word_t'(head_raw);
  assign rd_data  = head.data;
  assign rd_eop   = head.eop;
  assign rd_stat  = head.stat;
  assign ovr_flag = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_ev)  ovr_q <= 1'b1;
    else if (ovr_clr) ovr_q <= 1'b0;
  end

  // R9: the overrun flag holds until cleared
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !ovr_clr |=> ovr_q);
endmodule

// File: tb/hdlc_tdm_rx_test.sv
`timescale 1ns/1ps
module hdlc_tdm_rx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tdm_bit_en = 1'b0, tdm_fsync = 1'b0, tdm_data = 1'b0;
  logic [31:0] slot_mask = '0;
  logic [7:0]  bit_sup = '0;
  logic rd_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic rd_eop, rd_empty, rd_full, ovr_flag;
  logic [1:0] rd_stat;
  logic [8:0] rd_level;

  hdlc_tdm_rx uut (
    .clk(clk), .rst_n(rst_n), .tdm_bit_en(tdm_bit_en), .tdm_fsync(tdm_fsync),
    .tdm_data(tdm_data), .slot_mask(slot_mask), .bit_sup(bit_sup), .rd_en(rd_en),
    .rd_data(rd_data), .rd_eop(rd_eop), .rd_stat(rd_stat), .rd_level(rd_level),
    .rd_empty(rd_empty), .rd_full(rd_full), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int pos = 0;
  int run = 0;
  logic [7:0] pay [300];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic b);
    @(negedge clk);
    tdm_bit_en = 1'b1; tdm_data = b; tdm_fsync = (pos == 0);
    @(posedge clk);
    pos = (pos + 1) % 256;
  endtask

  // Places one HDLC bit in the next selected TDM position; others carry 0.
  task automatic put_bit(input logic b);
    while (!(slot_mask[pos / 8] && !bit_sup[pos % 8])) tick(1'b0);
    tick(b);
  endtask

  task automatic put_data_bit(input logic b);
    put_bit(b);
    run = b ? run + 1 : 0;
    if (run == 5) begin put_bit(1'b0); run = 0; end
  endtask

  task automatic send_flag();
    put_bit(1'b0);
    repeat (6) put_bit(1'b1);
    put_bit(1'b0);
    run = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_data_bit(v[i]);
  endtask

  function automatic logic [15:0] bench_fcs(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, pay[i]};
      repeat (8) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  // Sends flag, payload, check sequence; optionally corrupts it; closes with a flag.
  task automatic send_frame(input int n, input logic [15:0] flip, input bit close);
    logic [15:0] f;
    f = bench_fcs(n) ^ flip;
    send_flag();
    for (int i = 0; i < n; i++) send_byte(pay[i]);
    send_byte(f[7:0]);
    send_byte(f[15:8]);
    if (close) send_flag();
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    tdm_bit_en = 1'b0; tdm_fsync = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(output logic [7:0] d, output logic e, output logic [1:0] s);
    @(negedge clk);
    d = rd_data; e = rd_eop; s = rd_stat; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain_expect(input int n, input int last_stat, input string req);
    logic [7:0] d; logic e; logic [1:0] s;
    chk(rd_level == 9'(n), {req, " level"}, rd_level, n);
    for (int i = 0; i < n; i++) begin
      pop(d, e, s);
      chk(d == pay[i], {req, " data"}, d, pay[i]);
      chk(e == (i == n - 1), {req, " eop"}, e, (i == n - 1));
      if (i == n - 1) chk(s == 2'(last_stat), {req, " status"}, s, last_stat);
    end
    @(negedge clk);
    chk(rd_empty, {req, " empty after drain"}, rd_empty, 1);
  endtask

  task automatic fill_pay(input int n, input int seed);
    for (int i = 0; i < n; i++) pay[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
    if (n > 1) pay[1] = 8'h7E;
    if (n > 2) pay[2] = 8'hFF;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] masks [3];
    logic [7:0]  sups [3];
    logic [7:0] d; logic e; logic [1:0] s;
    bit seen_eop_early;
    masks[0] = 32'h8000_0005; sups[0] = 8'h21;
    masks[1] = 32'h0F0F_0F0F; sups[1] = 8'h00;
    masks[2] = 32'hFFFF_FFFF; sups[2] = 8'h80;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rd_empty == 1'b1, "R10 empty", rd_empty, 1);
    chk(rd_level == 9'd0, "R10 level", rd_level, 0);
    chk(rd_full == 1'b0, "R10 full", rd_full, 0);
    chk(ovr_flag == 1'b0, "R10 overrun", ovr_flag, 0);

    // Sweep masks (R1, R2) and frame lengths (R3, R4, R5, R7, R8)
    for (int m = 0; m < 3; m++) begin
      slot_mask = masks[m]; bit_sup = sups[m];
      for (int n = 0; n <= 6; n++) begin
        fill_pay(n, m * 7 + n);
        send_frame(n, 16'h0000, 1'b1);
        idle(3);
        if (n >= 2) drain_expect(n, 0, "R1 R2 R3 R4 R5 R8 good frame");
        else chk(rd_level == 9'd0, "R7 short frame dropped", rd_level, 0);
      end
    end

    slot_mask = masks[2]; bit_sup = sups[2];
    // R5 corrupted check sequence
    fill_pay(5, 40);
    send_frame(5, 16'h0100, 1'b1);
    idle(3);
    drain_expect(5, 1, "R5 crc error");

    // R5 frame that is not a whole number of bytes: stores data plus one byte with status 1
    fill_pay(5, 41);
    send_frame(5, 16'h0000, 1'b0);
    repeat (3) put_data_bit(1'b0);
    send_flag();
    idle(3);
    chk(rd_level == 9'd6, "R5 misaligned level", rd_level, 6);
    for (int i = 0; i < 6; i++) begin
      pop(d, e, s);
      if (i < 5) chk(d == pay[i] && !e, "R5 misaligned data", d, pay[i]);
      else chk(e && s == 2'd1, "R5 misaligned status", s, 1);
    end

    // R6 abort after five bytes, then noise without a flag, then a good frame
    fill_pay(5, 42);
    pay[4] = 8'h12;
    send_flag();
    for (int i = 0; i < 5; i++) send_byte(pay[i]);
    repeat (8) put_bit(1'b1);
    for (int i = 0; i < 16; i++) put_bit(i[0]);
    idle(3);
    drain_expect(3, 2, "R6 abort");
    fill_pay(3, 43);
    send_frame(3, 16'h0000, 1'b1);
    idle(3);
    drain_expect(3, 0, "R6 recovery after abort");

    // R8 R9 overrun: fill with a 250-byte frame, overflow during the next one
    fill_pay(250, 44);
    send_frame(250, 16'h0000, 1'b1);
    idle(3);
    chk(rd_level == 9'd250, "R8 large level", rd_level, 250);
    fork
      begin
        fill_pay(10, 45);
        send_frame(10, 16'h0000, 1'b1);
      end
      begin
        wait (ovr_flag == 1'b1);
        @(negedge clk);
        chk(rd_full == 1'b1, "R8 full at 256", rd_full, 1);
        chk(rd_level == 9'd256, "R8 level at 256", rd_level, 256);
        for (int i = 0; i < 20; i++) begin
          pop(d, e, s);
          chk(d == 8'(((i * 37 + 44 * 11 + 5) & 8'hFF) ^ ((i == 1) ? (((i * 37 + 44 * 11 + 5) & 8'hFF) ^ 8'h7E) : (i == 2) ? (((i * 37 + 44 * 11 + 5) & 8'hFF) ^ 8'hFF) : 0)),
              "R9 first frame kept", d, i);
        end
      end
    join
    idle(3);
    chk(ovr_flag == 1'b1, "R9 sticky overrun", ovr_flag, 1);
    for (int i = 20; i < 250; i++) begin
      pop(d, e, s);
      if (i == 249) chk(e && s == 2'd0, "R9 first frame good eop", s, 0);
    end
    seen_eop_early = 0;
    while (!rd_empty) begin
      pop(d, e, s);
      @(negedge clk);
      if (e && !rd_empty) seen_eop_early = 1;
      if (rd_empty) chk(e && s == 2'd3, "R9 overrun status", s, 3);
    end
    chk(!seen_eop_early, "R9 single eop in overrun frame", seen_eop_early, 0);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R9 overrun cleared", ovr_flag, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule